// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block produces the two comparison pulses that a phase-locked loop synthesizer feeds to its phase detector. The main path divides a stream of input clock ticks by a programmable ratio P·N+A. It does this with three parts: a dual-modulus prescaler that counts either P or P+1 ticks, a swallow counter A that keeps the prescaler at P+1, and a programmable counter N that counts prescaler cycles. The reference path divides a second tick stream by R. Both paths run in one synchronous clock domain. Each input stream is a per-cycle enable, and the prescaler is ordinary logic.

The ratio inputs are expected to come straight from programming latches. The divider samples them only when a count finishes, so a new setting never cuts a period short. A setting with A≥N or N below 16 is flagged on `cfg_err` and is not used. The same applies to a reference ratio below 8. In either case the divider keeps running on the last accepted values.

Top module: `pulse_swallow_divider`

## Requirements
- R1: With every cycle enabled, `fp_pulse` repeats every P·N+A cycles, where P is 32 when `sel_small`=1 and 64 when `sel_small`=0.
- R2: Each main period holds A prescaler cycles of P+1 ticks and N−A cycles of P ticks. The ratio is exact at the boundaries A=0 (P·N) and A=N−1.
- R3: With every cycle enabled, `fr_pulse` repeats every R cycles for any R from 8 to 16383.
- R4: `fp_pulse` is high for exactly one cycle, in the cycle after the edge that consumes the final tick of a main period.
- R5: `fr_pulse` is high for exactly one cycle, in the cycle after the edge that consumes the final reference tick.
- R6: Only cycles with `vco_en`=1 advance the main path, and only cycles with `ref_en`=1 advance the reference path. Enabling every other cycle doubles both periods.
- R7: `n_ratio`, `a_ratio`, `sel_small` and `r_ratio` are sampled only at the terminal count of their own path. A change made mid-period leaves that period's length unchanged.
- R8: `cfg_err` is high whenever a_ratio≥n_ratio, n_ratio<16 or r_ratio<8. An invalid main or reference setting is ignored at the terminal count, and the path keeps its previous ratio.
- R9: After reset both pulses are low and the first periods use P=32, N=16, A=0 (512 ticks) and R=8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_en | input | 1 | Main input tick |
| ref_en | input | 1 | Reference input tick |
| sel_small | input | 1 | Prescaler pair: 1 = 32/33, 0 = 64/65 |
| n_ratio | input | 11 | Programmable counter ratio N |
| a_ratio | input | 7 | Swallow counter ratio A |
| r_ratio | input | 14 | Reference ratio R |
| fp_pulse | output | 1 | Main divided pulse |
| fr_pulse | output | 1 | Reference divided pulse |
| cfg_err | output | 1 | Presented setting is invalid |

## Verification
The bench builds the block with its default parameters: 11-bit N, 7-bit A, 14-bit R and the 32/64 prescaler pair. Random N values are kept below 48 so that each period lasts a few thousand cycles. That keeps both prescaler moduli, the A=0 and A=N−1 edges, the minimum N and R, invalid settings, mid-period changes and half-rate enables inside a short run.

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider #(
  parameter int NW      = 11,
  parameter int AW      = 7,
  parameter int RW      = 14,
  parameter int P_SMALL = 32,
  parameter int P_LARGE = 64,
  parameter int N_MIN   = 16,
  parameter int R_MIN   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vco_en,
  input  logic          ref_en,
  input  logic          sel_small,
  input  logic [NW-1:0] n_ratio,
  input  logic [AW-1:0] a_ratio,
  input  logic [RW-1:0] r_ratio,
  output logic          fp_pulse,
  output logic          fr_pulse,
  output logic          cfg_err
);
  localparam int PCW = $clog2(P_LARGE + 1);

  logic [PCW-1:0] pc;
  logic [NW-1:0]  n_cnt, n_act;
  logic [AW-1:0]  a_cnt, a_act;
  logic           small_act;
  logic [RW-1:0]  r_cnt, r_act;

  logic           swallow, pre_tc, main_tc, main_ok, ref_tc, ref_ok;
  logic [PCW-1:0] pc_last;

  assign swallow = (a_cnt != '0);
  assign pc_last = (small_act ? PCW'(P_SMALL - 1) : PCW'(P_LARGE - 1))
                 + {{(PCW-1){1'b0}}, swallow};
  assign pre_tc  = vco_en && (pc == pc_last);
  assign main_tc = pre_tc && (n_cnt == NW'(1));
  assign main_ok = ({{(NW-AW){1'b0}}, a_ratio} < n_ratio) && (n_ratio >= NW'(N_MIN));
  assign ref_tc  = ref_en && (r_cnt == RW'(1));
  assign ref_ok  = (r_ratio >= RW'(R_MIN));
  assign cfg_err = !main_ok || !ref_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc        <= '0;
      n_cnt     <= NW'(N_MIN);
      a_cnt     <= '0;
      n_act     <= NW'(N_MIN);
      a_act     <= '0;
      small_act <= 1'b1;
      fp_pulse  <= 1'b0;
    end else begin
      fp_pulse <= main_tc;
      if (pre_tc) begin
        pc <= '0;
        if (main_tc) begin
          if (main_ok) begin
            n_act     <= n_ratio;
            a_act     <= a_ratio;
            small_act <= sel_small;
            n_cnt     <= n_ratio;
            a_cnt     <= a_ratio;
          end else begin
            n_cnt <= n_act;
            a_cnt <= a_act;
          end
        end else begin
          n_cnt <= n_cnt - NW'(1);
          if (swallow) a_cnt <= a_cnt - AW'(1);
        end
      end else if (vco_en) begin
        pc <= pc + PCW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_cnt    <= RW'(R_MIN);
      r_act    <= RW'(R_MIN);
      fr_pulse <= 1'b0;
    end else begin
      fr_pulse <= ref_tc;
      if (ref_tc) begin
        if (ref_ok) begin
          r_cnt <= r_ratio;
          r_act <= r_ratio;
        end else begin
          r_cnt <= r_act;
        end
      end else if (ref_en) begin
        r_cnt <= r_cnt - RW'(1);
      end
    end
  end

  p_prescaler_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pc <= pc_last);

  p_swallow_below_n_r2: assert property (@(posedge clk) disable iff (!rst_n)
    {{(NW-AW){1'b0}}, a_cnt} < n_cnt);

  p_fp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fp_pulse |=> !fp_pulse);

  p_fr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fr_pulse && r_act > RW'(1) |=> !fr_pulse);

  p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !vco_en |=> $stable(pc) && $stable(n_cnt) && !fp_pulse);

  p_no_midcycle_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !main_tc |=> $stable(n_act) && $stable(a_act) && $stable(small_act));

  p_invalid_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    main_tc && cfg_err && !main_ok |=> $stable(n_act) && $stable(a_act));

  p_ref_invalid_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tc && !ref_ok |=> $stable(r_act));
endmodule

// File: tb/test_pulse_swallow_divider.sv
module test_pulse_swallow_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vco_en = 1'b0, ref_en = 1'b0, sel_small = 1'b1;
  logic [10:0] n_ratio = 11'd20;
  logic [6:0]  a_ratio = 7'd3;
  logic [13:0] r_ratio = 14'd100;
  logic        fp_pulse, fr_pulse, cfg_err;

  int checks = 0, fails = 0;
  bit gate = 1'b0, done = 1'b0;

  always #2 clk = ~clk;

  pulse_swallow_divider i_pulse_swallow_divider (
    .clk(clk), .rst_n(rst_n), .vco_en(vco_en), .ref_en(ref_en),
    .sel_small(sel_small), .n_ratio(n_ratio), .a_ratio(a_ratio),
    .r_ratio(r_ratio), .fp_pulse(fp_pulse), .fr_pulse(fr_pulse),
    .cfg_err(cfg_err));

  function automatic int main_ratio(bit s, int n, int a);
    return (s ? 32 : 64) * n + a;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (gate) begin
      vco_en = ~vco_en;
      ref_en = ~ref_en;
    end
  endtask

  task automatic wait_fp(output int cyc);
    cyc = 0;
    do begin step(); cyc++; end while (!fp_pulse && cyc < 400000);
  endtask

  task automatic wait_fr(output int cyc);
    cyc = 0;
    do begin step(); cyc++; end while (!fr_pulse && cyc < 400000);
  endtask

  task automatic set_main(bit s, int n, int a);
    sel_small = s; n_ratio = 11'(n); a_ratio = 7'(a);
  endtask

  task automatic run_main(string req, bit s, int n, int a);
    int c;
    set_main(s, n, a);
    wait_fp(c);
    wait_fp(c);
    check(req, c, main_ratio(s, n, a));
  endtask

  task automatic run_ref(string req, int r);
    int c;
    r_ratio = 14'(r);
    wait_fr(c);
    wait_fr(c);
    check(req, c, r);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int c, fpc, frc, n, a, r;
    bit s;
    void'($urandom(32'd4242));
    vco_en = 1'b1; ref_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 fp low in reset", int'(fp_pulse), 0);
    check("R9 fr low in reset", int'(fr_pulse), 0);
    rst_n = 1'b1;
    fpc = 0; frc = 0; c = 0;
    while ((fpc == 0 || frc == 0) && c < 2000) begin
      step(); c++;
      if (fr_pulse && frc == 0) frc = c;
      if (fp_pulse && fpc == 0) fpc = c;
    end
    check("R9 first fp after default 512", fpc, 512);
    check("R9 first fr after default R=8", frc, 8);
    check("R8 valid inputs no cfg_err", int'(cfg_err), 0);

    // R1 / R2 directed
    run_main("R1 P=64 N=20 A=3", 1'b0, 20, 3);
    run_main("R2 A=0 gives P*N", 1'b1, 16, 0);
    run_main("R2 A=N-1 at N_min, P=65 side", 1'b0, 16, 15);
    run_main("R2 A=N-1 P=32", 1'b1, 37, 36);

    // R4 single-cycle pulse
    set_main(1'b1, 16, 0);
    wait_fp(c); wait_fp(c);
    step();
    check("R4 fp single cycle", int'(fp_pulse), 0);

    // R1 / R2 random
    for (int i = 0; i < 8; i++) begin
      s = 1'($urandom_range(0, 1));
      n = int'($urandom_range(16, 47));
      a = int'($urandom_range(0, n - 1));
      run_main("R1 random ratio", s, n, a);
    end

    // R3 reference
    run_ref("R3 R=8 minimum", 8);
    run_ref("R3 R=16383 maximum", 16383);
    for (int i = 0; i < 5; i++) begin
      r = int'($urandom_range(8, 600));
      run_ref("R3 random R", r);
    end
    r_ratio = 14'd9;
    wait_fr(c); wait_fr(c);
    step();
    check("R5 fr single cycle", int'(fr_pulse), 0);

    // R7 mid-period change
    set_main(1'b1, 20, 5);
    wait_fp(c); wait_fp(c);
    repeat (100) step();
    set_main(1'b0, 16, 15);
    wait_fp(c);
    check("R7 mid-period change ignored", c, 645 - 100);
    wait_fp(c);
    check("R7 change applied next period", c, 1039);
    r_ratio = 14'd300;
    wait_fr(c); wait_fr(c);
    repeat (50) step();
    r_ratio = 14'd40;
    wait_fr(c);
    check("R7 reference mid-period change ignored", c, 250);
    wait_fr(c);
    check("R7 reference new ratio", c, 40);

    // R8 invalid settings
    set_main(1'b1, 20, 5);
    wait_fp(c); wait_fp(c);
    set_main(1'b0, 20, 25);
    step();
    check("R8 cfg_err on A>=N", int'(cfg_err), 1);
    wait_fp(c); wait_fp(c);
    check("R8 A>=N ignored, ratio held", c, 645);
    set_main(1'b0, 20, 20);
    step();
    check("R8 cfg_err on A==N", int'(cfg_err), 1);
    set_main(1'b0, 10, 0);
    step();
    check("R8 cfg_err on N<16", int'(cfg_err), 1);
    wait_fp(c); wait_fp(c);
    check("R8 N<16 ignored, ratio held", c, 645);
    set_main(1'b1, 20, 5);
    r_ratio = 14'd5;
    step();
    check("R8 cfg_err on R<8", int'(cfg_err), 1);
    wait_fr(c); wait_fr(c);
    check("R8 R<8 ignored, R held", c, 40);
    r_ratio = 14'd40;
    step();
    check("R8 cfg_err clears", int'(cfg_err), 0);

    // R6 half-rate enables
    set_main(1'b1, 20, 5);
    wait_fp(c);
    gate = 1'b1;
    wait_fp(c); wait_fp(c);
    check("R6 half-rate doubles fp period", c, 2 * 645);
    wait_fr(c); wait_fr(c);
    check("R6 half-rate doubles fr period", c, 80);
    gate = 1'b0; vco_en = 1'b1; ref_en = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule